// File: doc/BRIEF.md
# Bang-Bang Digital PLL Loop Filter

This block is the digital heart of a type-II digital phase-locked loop whose oscillator multiplies a 109.375 MHz reference by 64 to reach 7 GHz. Once per reference cycle it receives a single early/late bit from the flip-flop that quantises the phase/frequency detector output. It runs that bit through a proportional-plus-integral filter whose two gains are powers of two. The filter output is an 8-bit fine frequency word, clamped to its range. The word is also expanded into a 256-line thermometer bus for the oscillator's unit-weighted fine tuning bank.

A 7-bit binary coarse band select drives the oscillator's coarse bank. After reset the block either takes a band programmed during reset, or finds one by a single binary search. The search sets one band bit per step and averages the error bit over a fixed window before it settles that bit. While the search runs, the fine word is held at mid-scale. Closed-loop tracking starts from mid-scale once the search completes.

The gains and the band programming are sampled only while reset is asserted. The loop clock is the reference clock.

Top module: `dpll_loop_core`

## Requirements
- R1: While reset is asserted (synchronous, active low), the block sets the fine word to 128 and lowers the search-done flag. With band programming disabled it sets the coarse band to 64; with it enabled it sets the band to the programmed value.
- R2: The integral accumulator is 16 bits wide and starts at 32768. On every clock edge after the search completes, it adds 2^ki_shift when err_up is 1 (oscillator too slow) and subtracts 2^ki_shift when err_up is 0.
- R3: At the same edge, the fine word becomes bits 15:8 of the sum of the new accumulator value and the proportional term. The proportional term is +2^kp_shift when err_up is 1 and -2^kp_shift when err_up is 0.
- R4: The accumulator and the sum are each clamped to the range 0..65535. A clamped accumulator holds its limit and never wraps. For example, with kp_shift=0 and ki_shift=12, ten up cycles give 255 and one further down cycle gives 239.
- R5: fine_therm line i is 1 exactly when i < fine_word. For a word k, lines 0..k-1 are set and all others are clear.
- R6: kp_shift and ki_shift take effect only as sampled during reset; changing them while the loop runs has no effect.
- R7: With band programming disabled, the search runs 7 windows of 16 cycles each, testing bits 6 down to 0. The trial bit stays set only if more than 8 of the window's 16 error bits are 1. search_done rises exactly 112 clock edges after reset is released and then stays high.
- R8: While the search runs, the fine word stays at 128, and the coarse band changes only at the last edge of a window.
- R9: With band programming enabled during reset, no search takes place. search_done is high from reset onward and the coarse band keeps the programmed value.
- R10: Driven by a monotonic oscillator model, the search picks the highest band whose mid-scale frequency is below target. The loop then brings the fine word to the value that meets the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate loop clock |
| rst_n | input | 1 | Synchronous active-low reset; gains and band programming sampled while low |
| err_up | input | 1 | Quantised phase error: 1 = oscillator slow (raise frequency), 0 = fast |
| kp_shift | input | 4 | Proportional gain exponent |
| ki_shift | input | 4 | Integral gain exponent |
| band_prog_en | input | 1 | 1 = use band_prog and skip the band search |
| band_prog | input | 7 | Programmed coarse band |
| fine_word | output | 8 | Clamped fine frequency word |
| fine_therm | output | 256 | Thermometer code of fine_word for the fine tuning bank |
| coarse_band | output | 7 | Binary coarse band select |
| search_done | output | 1 | High once the coarse band is final and the filter is tracking |

## Verification
The assertions assume that err_up is a clean synchronous bit that is valid at every rising edge. They also assume that gains and band programming are written only during reset, so the step-direction checks can rely on fixed gains. The bench changes every input on the falling edge. In closed loop, err_up is derived only from the registered outputs through an oscillator model, so it is stable before each rising edge. The search majority rule is checked with window patterns one bit on each side of the threshold.

// File: rtl/dlf_pkg.sv
package dlf_pkg;

  // Loop phase: band search first, then proportional-integral tracking.
  typedef enum logic {
    PH_SEARCH = 1'b0,
    PH_RUN    = 1'b1
  } phase_e;

  // Encoding of the quantised phase error bit.
  localparam logic ERR_RAISE = 1'b1;

endpackage

// File: rtl/dlf_pi_filter.sv
module dlf_pi_filter #(
  parameter int ACC_W   = 16,
  parameter int FINE_W  = 8,
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic               err_up_i,
  input  logic [SHIFT_W-1:0] kp_sh_i,
  input  logic [SHIFT_W-1:0] ki_sh_i,
  output logic [FINE_W-1:0]  fine_o
);

  localparam int SUM_W = ACC_W + 2;
  localparam logic [ACC_W-1:0] ACC_MID = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic signed [SUM_W-1:0] ACC_MAX = $signed({2'b00, {ACC_W{1'b1}}});
  localparam logic [FINE_W-1:0] FINE_MID = ACC_MID[ACC_W-1 -: FINE_W];

  // Clamp a signed intermediate into the unsigned accumulator range.
  function automatic logic [ACC_W-1:0] clamp_acc(input logic signed [SUM_W-1:0] v);
    if (v < 0)            return '0;
    else if (v > ACC_MAX) return '1;
    else                  return v[ACC_W-1:0];
  endfunction

  // +/- 2^sh according to the error direction.
  function automatic logic signed [SUM_W-1:0] signed_step(input logic up,
                                                           input logic [SHIFT_W-1:0] sh);
    logic signed [SUM_W-1:0] mag;
    mag = $signed({{(SUM_W-1){1'b0}}, 1'b1} << sh);
    return (up == dlf_pkg::ERR_RAISE) ? mag : -mag;
  endfunction

  function automatic logic signed [SUM_W-1:0] widen(input logic [ACC_W-1:0] a);
    return $signed({2'b00, a});
  endfunction

  logic [ACC_W-1:0]  integ_q;
  logic [ACC_W-1:0]  integ_nx;
  logic [ACC_W-1:0]  sum_nx;
  logic [FINE_W-1:0] fine_q;

  always_comb begin
    integ_nx = clamp_acc(widen(integ_q) + signed_step(err_up_i, ki_sh_i));
    sum_nx   = clamp_acc(widen(integ_nx) + signed_step(err_up_i, kp_sh_i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      integ_q <= ACC_MID;
      fine_q  <= FINE_MID;
    end else if (run_i) begin
      integ_q <= integ_nx;
      fine_q  <= sum_nx[ACC_W-1 -: FINE_W];
    end
  end

  assign fine_o = fine_q;

endmodule

// File: rtl/dlf_therm_enc.sv
module dlf_therm_enc #(
  parameter int FINE_W = 8
) (
  input  logic [FINE_W-1:0]       fine_i,
  output logic [(1<<FINE_W)-1:0]  therm_o
);

  localparam int LEVELS = 1 << FINE_W;

  for (genvar g = 0; g < LEVELS; g++) begin : g_line
    assign therm_o[g] = ({1'b0, fine_i} > (FINE_W+1)'(g));
  end

endmodule

// File: rtl/dlf_band_search.sv
module dlf_band_search #(
  parameter int BAND_W  = 7,
  parameter int AVG_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en_i,
  input  logic [BAND_W-1:0] prog_band_i,
  input  logic              err_up_i,
  output logic [BAND_W-1:0] band_o,
  output logic              done_o,
  output logic              win_end_o
);

  import dlf_pkg::*;

  localparam int IDX_W = (BAND_W > 1) ? $clog2(BAND_W) : 1;
  localparam int CNT_W = $clog2(AVG_LEN + 1);
  localparam logic [BAND_W-1:0] BAND_START = {1'b1, {(BAND_W-1){1'b0}}};
  localparam logic [CNT_W-1:0]  CNT_LAST   = CNT_W'(AVG_LEN - 1);
  localparam logic [IDX_W-1:0]  IDX_TOP    = IDX_W'(BAND_W - 1);

  // Strict majority of "raise" decisions keeps the trial bit.
  function automatic logic window_keep(input logic [CNT_W-1:0] ups);
    return (int'(ups) * 2) > AVG_LEN;
  endfunction

  phase_e            phase_q;
  logic [BAND_W-1:0] band_q;
  logic [BAND_W-1:0] band_nx;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  ups_q;
  logic [CNT_W-1:0]  ups_tot;
  logic              searching;
  logic              win_end;

  assign searching = (phase_q == PH_SEARCH);
  assign ups_tot   = ups_q + CNT_W'(err_up_i);
  assign win_end   = searching && (cnt_q == CNT_LAST);

  always_comb begin
    band_nx = band_q;
    if (!window_keep(ups_tot)) band_nx[idx_q] = 1'b0;
    if (idx_q != '0)           band_nx[idx_q - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= prog_en_i ? PH_RUN : PH_SEARCH;
      band_q  <= prog_en_i ? prog_band_i : BAND_START;
      idx_q   <= IDX_TOP;
      cnt_q   <= '0;
      ups_q   <= '0;
    end else if (searching) begin
      if (win_end) begin
        band_q <= band_nx;
        cnt_q  <= '0;
        ups_q  <= '0;
        idx_q  <= idx_q - 1'b1;
        if (idx_q == '0) phase_q <= PH_RUN;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        ups_q <= ups_tot;
      end
    end
  end

  assign band_o    = band_q;
  assign done_o    = !searching;
  assign win_end_o = win_end;

endmodule

// File: rtl/dpll_loop_core.sv
module dpll_loop_core #(
  parameter int FINE_W  = 8,
  parameter int ACC_W   = 16,
  parameter int BAND_W  = 7,
  parameter int SHIFT_W = 4,
  parameter int AVG_LEN = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    err_up,
  input  logic [SHIFT_W-1:0]      kp_shift,
  input  logic [SHIFT_W-1:0]      ki_shift,
  input  logic                    band_prog_en,
  input  logic [BAND_W-1:0]       band_prog,
  output logic [FINE_W-1:0]       fine_word,
  output logic [(1<<FINE_W)-1:0]  fine_therm,
  output logic [BAND_W-1:0]       coarse_band,
  output logic                    search_done
);

  // Gains are captured only while the loop is held in reset.
  logic [SHIFT_W-1:0] kp_q;
  logic [SHIFT_W-1:0] ki_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kp_q <= kp_shift;
      ki_q <= ki_shift;
    end
  end

  // Named internal events used by the checker.
  logic filt_run;
  logic win_end;

  dlf_band_search #(
    .BAND_W  (BAND_W),
    .AVG_LEN (AVG_LEN)
  ) search_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .prog_en_i   (band_prog_en),
    .prog_band_i (band_prog),
    .err_up_i    (err_up),
    .band_o      (coarse_band),
    .done_o      (filt_run),
    .win_end_o   (win_end)
  );

  dlf_pi_filter #(
    .ACC_W   (ACC_W),
    .FINE_W  (FINE_W),
    .SHIFT_W (SHIFT_W)
  ) filter_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (filt_run),
    .err_up_i (err_up),
    .kp_sh_i  (kp_q),
    .ki_sh_i  (ki_q),
    .fine_o   (fine_word)
  );

  dlf_therm_enc #(
    .FINE_W (FINE_W)
  ) therm_i (
    .fine_i  (fine_word),
    .therm_o (fine_therm)
  );

  assign search_done = filt_run;

endmodule

// File: rtl/dlf_checker.sv
module dlf_checker #(
  parameter int FINE_W = 8,
  parameter int BAND_W = 7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   err_up,
  input logic [FINE_W-1:0]      fine_word,
  input logic [(1<<FINE_W)-1:0] fine_therm,
  input logic [BAND_W-1:0]      coarse_band,
  input logic                   search_done,
  input logic                   filt_run,
  input logic                   win_end
);

  localparam logic [FINE_W-1:0] FINE_MID = {1'b1, {(FINE_W-1){1'b0}}};

  // R5
  therm_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fine_therm) == int'(fine_word));

  // R5
  therm_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fine_therm + 1'b1) & fine_therm) == '0);

  // R8
  search_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !search_done |-> (fine_word == FINE_MID));

  // R8
  band_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!search_done && !win_end) |=> $stable(coarse_band));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    search_done |=> search_done);

  // R2
  raise_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_run && err_up) |=> (fine_word >= $past(fine_word)));

  // R3
  lower_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_run && !err_up) |=> (fine_word <= $past(fine_word)));

  // R9
  run_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
    filt_run |=> $stable(coarse_band));

endmodule

bind dpll_loop_core dlf_checker #(
  .FINE_W (FINE_W),
  .BAND_W (BAND_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .err_up      (err_up),
  .fine_word   (fine_word),
  .fine_therm  (fine_therm),
  .coarse_band (coarse_band),
  .search_done (search_done),
  .filt_run    (filt_run),
  .win_end     (win_end)
);

// File: tb/dpll_loop_core_tb.sv
module dpll_loop_core_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         err_forced = 1'b0;
  logic         use_model = 1'b0;
  logic         err_up;
  logic [3:0]   kp_shift = 4'd0;
  logic [3:0]   ki_shift = 4'd0;
  logic         band_prog_en = 1'b0;
  logic [6:0]   band_prog = 7'd0;
  logic [7:0]   fine_word;
  logic [255:0] fine_therm;
  logic [6:0]   coarse_band;
  logic         search_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dpll_loop_core dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .err_up       (err_up),
    .kp_shift     (kp_shift),
    .ki_shift     (ki_shift),
    .band_prog_en (band_prog_en),
    .band_prog    (band_prog),
    .fine_word    (fine_word),
    .fine_therm   (fine_therm),
    .coarse_band  (coarse_band),
    .search_done  (search_done)
  );

  // Behavioural oscillator: frequency in kHz from band and fine word.
  localparam longint F_BASE   = 5_600_000;
  localparam longint F_COARSE = 20_000;
  localparam longint F_FINE   = 200;
  localparam longint F_TARGET = 7_000_000; // 64 x 109.375 MHz

  function automatic longint osc_khz(input int band, input int fine);
    return F_BASE + longint'(band) * F_COARSE + longint'(fine) * F_FINE;
  endfunction

  assign err_up = use_model ? (osc_khz(int'(coarse_band), int'(fine_word)) < F_TARGET)
                            : err_forced;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_therm(input string tag, input int k);
    logic [255:0] exp_t;
    for (int i = 0; i < 256; i++) exp_t[i] = (i < k);
    check(fine_therm == exp_t, tag, $countones(fine_therm), k);
  endtask

  task automatic do_reset(input int kp, input int ki, input bit pen, input int pb);
    @(negedge clk);
    rst_n        = 1'b0;
    use_model    = 1'b0;
    kp_shift     = 4'(kp);
    ki_shift     = 4'(ki);
    band_prog_en = pen;
    band_prog    = 7'(pb);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_err(input bit up, input int n);
    err_forced = up;
    for (int c = 0; c < n; c++) @(negedge clk);
  endtask

  // Table: {kp[24:21], ki[20:17], up[16], n[15:8], expected fine[7:0]}
  localparam logic [24:0] VECS [0:7] = '{
    {4'd10, 4'd8,  1'b1, 8'd3,  8'd135},
    {4'd10, 4'd8,  1'b0, 8'd3,  8'd121},
    {4'd12, 4'd9,  1'b1, 8'd2,  8'd148},
    {4'd0,  4'd12, 1'b1, 8'd10, 8'd255},
    {4'd0,  4'd12, 1'b0, 8'd10, 8'd0},
    {4'd15, 4'd0,  1'b1, 8'd1,  8'd255},
    {4'd15, 4'd0,  1'b0, 8'd1,  8'd0},
    {4'd8,  4'd8,  1'b1, 8'd1,  8'd130}
  };

  initial begin
    #5_000_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state with search pending
    do_reset(6, 6, 1'b0, 0);
    check(fine_word == 8'd128, "R1 reset fine", fine_word, 128);
    check(coarse_band == 7'd64, "R1 reset band", coarse_band, 64);
    check(search_done == 1'b0, "R1 reset done", search_done, 0);
    check_therm("R5 reset therm", 128);

    // R1 R9: programmed band in reset
    do_reset(6, 6, 1'b1, 37);
    check(coarse_band == 7'd37, "R1 programmed band", coarse_band, 37);
    check(search_done == 1'b1, "R9 done with programmed band", search_done, 1);

    // Table walk: R2 R3 R4 R5 R9
    foreach (VECS[v]) begin
      do_reset(int'(VECS[v][24:21]), int'(VECS[v][20:17]), 1'b1, v * 9 + 5);
      err_forced = VECS[v][16];
      rst_n = 1'b1;
      run_err(VECS[v][16], int'(VECS[v][15:8]));
      check(fine_word == VECS[v][7:0], "R2 R3 R4 table fine", fine_word, int'(VECS[v][7:0]));
      check_therm("R5 table therm", int'(VECS[v][7:0]));
      check(coarse_band == 7'(v * 9 + 5), "R9 table band", coarse_band, v * 9 + 5);
    end

    // R3: proportional term flips sign with the error
    do_reset(10, 8, 1'b1, 20);
    rst_n = 1'b1;
    run_err(1'b1, 1);
    run_err(1'b0, 1);
    check(fine_word == 8'd124, "R3 up then down", fine_word, 124);

    // R4: clamped accumulator holds instead of wrapping
    do_reset(0, 12, 1'b1, 20);
    rst_n = 1'b1;
    run_err(1'b1, 10);
    check(fine_word == 8'd255, "R4 clamp high", fine_word, 255);
    run_err(1'b0, 1);
    check(fine_word == 8'd239, "R4 release from clamp", fine_word, 239);

    // R6: gain changes while running are ignored
    do_reset(10, 8, 1'b1, 20);
    rst_n = 1'b1;
    kp_shift = 4'd0;
    ki_shift = 4'd0;
    run_err(1'b1, 3);
    check(fine_word == 8'd135, "R6 gains fixed after reset", fine_word, 135);

    // R7: majority threshold, one below and one above half
    for (int k = 8; k <= 9; k++) begin
      do_reset(6, 6, 1'b0, 0);
      rst_n = 1'b1;
      for (int w = 0; w < 7; w++) begin
        for (int c = 0; c < 16; c++) begin
          err_forced = (c < k);
          @(negedge clk);
        end
      end
      check(search_done == 1'b1, "R7 done after 112 cycles", search_done, 1);
      check(coarse_band == ((k == 8) ? 7'd0 : 7'd127), "R7 majority rule",
            coarse_band, (k == 8) ? 0 : 127);
    end

    // R7 R8 R10: search and tracking against the oscillator model
    do_reset(6, 6, 1'b0, 0);
    use_model = 1'b1;
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    check(fine_word == 8'd128, "R8 fine held during search", fine_word, 128);
    repeat (71) @(negedge clk);
    check(search_done == 1'b0, "R7 not done after 111 cycles", search_done, 0);
    @(negedge clk);
    check(search_done == 1'b1, "R7 done at 112 cycles", search_done, 1);
    begin
      int exp_band;
      exp_band = 0;
      for (int b = 0; b < 128; b++)
        if (osc_khz(b, 128) < F_TARGET) exp_band = b;
      check(int'(coarse_band) == exp_band, "R10 band from search", coarse_band, exp_band);
    end
    repeat (2000) @(negedge clk);
    check(fine_word >= 8'd192 && fine_word <= 8'd208, "R10 fine settles near 200",
          fine_word, 200);
    check_therm("R5 tracking therm", int'(fine_word));

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule